// File: doc/BRIEF.md
# Status Register and Block Lock Guard

This block keeps the eight-bit status byte of a serial memory and decides, cycle by cycle, whether a write to the storage array or to the status register may begin. A command decoder elsewhere hands it one-cycle strobes. These strobes set or clear the write-enable latch, set or clear a general-purpose flag, request a status write with its data byte, and start an array write cycle. A separate self-timer reports the end of each internal write cycle. The block also sees the level of the write-protect pin and the array address that a pending write targets.

Two persistent bits select the locked fraction of the array: nothing, the top quarter, the top half, or all of it. Locked addresses stay readable, but `arr_wr_ok` is held low for them. A sticky protect-enable bit, combined with a low write-protect pin, puts the part in a hardware read-only mode in which every status write is refused. The persistent bits load from parameters at reset, because real nonvolatile storage lies outside this block. A status write is not applied when it is accepted. Its data waits until the self-timed cycle ends, and only then is it committed.

Top module: `stsreg_guard`

## Requirements
- R1: `status_q` reads, from bit 7 down to bit 0, {protect-enable, flag, 0, 0, lock-hi, lock-lo, write-enable, busy}. After reset the flag, write-enable and busy bits are 0, protect-enable equals `RST_WPEN` and the lock pair equals `RST_LOCK` (both 0 by default).
- R2: While busy is 0, `wel_set` sets write-enable one cycle later and `wel_clr` clears it; if both arrive together, clear wins. While busy is 1, both strobes are ignored.
- R3: `flag_set` sets the flag and `flag_clr` clears it at any time, clear winning when both arrive; no other event changes the flag.
- R4: The lock pair protects addresses as follows: 00 protects none, 01 protects 0x600 to 0x7FF, 10 protects 0x400 to 0x7FF, and 11 protects every address. `arr_wr_ok` is 0 for a protected `wr_addr`, and a `wcyc_start` to such an address leaves busy at 0.
- R5: `arr_wr_ok` and `sts_wr_ok` are both 0 whenever write-enable is 0 or busy is 1.
- R6: When protect-enable is 1 and `wp_pin_hi` is 0, `sts_wr_ok` is 0 and `sr_wr` changes nothing. With the pin high or protect-enable 0, status writes are gated only as in R5.
- R7: An `sr_wr` accepted while `sts_wr_ok` is 1 and `sr_wdata[1:0]` is 00 sets busy on the next cycle. The cycle after `wcyc_done`, protect-enable equals `sr_wdata[7]`, the lock pair equals `sr_wdata[3:2]`, and busy and write-enable are 0. Data bits 6 to 4 have no effect.
- R8: An `sr_wr` whose `sr_wdata[1:0]` is not 00 is refused: busy stays 0 and the persistent bits are unchanged.
- R9: A `wcyc_start` while `arr_wr_ok` is 1 sets busy on the next cycle. The cycle after `wcyc_done`, busy and write-enable are 0 and the persistent bits are unchanged. When an accepted `sr_wr` arrives in the same cycle, only the status write starts.
- R10: If the pin goes low, with protect-enable set, while a status write is in progress, that write still commits at `wcyc_done`. Later status writes are refused.
- R11: `wcyc_done` while busy is 0 has no effect on `status_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; loads persistent bits from parameters |
| wel_set | input | 1 | Strobe: set write-enable latch |
| wel_clr | input | 1 | Strobe: clear write-enable latch |
| flag_set | input | 1 | Strobe: set flag bit |
| flag_clr | input | 1 | Strobe: clear flag bit |
| sr_wr | input | 1 | Strobe: status write request |
| sr_wdata | input | 8 | Data byte for the status write |
| wcyc_start | input | 1 | Strobe: start an array write cycle |
| wcyc_done | input | 1 | Strobe: internal write cycle finished |
| wp_pin_hi | input | 1 | Level of the write-protect pin (1 = high) |
| wr_addr | input | ADDR_W | Array address targeted by a write |
| status_q | output | 8 | Readable status byte |
| arr_wr_ok | output | 1 | An array write to `wr_addr` may start now |
| sts_wr_ok | output | 1 | A status write may start now |

## Verification
Three pairs of events can fall in the same cycle. The first pair is the end of a write cycle and a write-enable command, where the command must lose because busy is still 1. The second is a commit of a status write and a fall of the protect pin, where the commit must still land. The third is a status request and an array start, where only the status write may begin. Random stimulus with a fixed seed fires these strobes independently every cycle, and an end-of-cycle strobe is likely while busy. These collisions therefore recur often, next to directed sequences that force each one on purpose. A reference model in the bench judges every cycle. It uses address comparisons rather than bit slices for the lock map, and it checks the status byte and both permit outputs.

// File: rtl/stsreg_pkg.sv
package stsreg_pkg;

  typedef enum logic { CYC_ARRAY = 1'b0, CYC_STATUS = 1'b1 } cyc_kind_t;

  // Lock map: top two address bits against the lock pair.
  function automatic logic lock_hit(input logic [1:0] lock, input logic [1:0] top2);
    case (lock)
      2'b00:   lock_hit = 1'b0;
      2'b01:   lock_hit = top2[1] & top2[0];
      2'b10:   lock_hit = top2[1];
      default: lock_hit = 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] pack_status(input logic wpen, input logic flag,
                                             input logic [1:0] lock, input logic wel,
                                             input logic busy);
    pack_status = {wpen, flag, 2'b00, lock, wel, busy};
  endfunction

endpackage

// File: rtl/stsreg_lock_decode.sv
module stsreg_lock_decode #(
  parameter int ADDR_W = 11
) (
  input  logic [1:0]        lock,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int TOP = ADDR_W - 1;

  logic [1:0] top2;
  assign top2 = addr[TOP -: 2];
  assign hit  = stsreg_pkg::lock_hit(lock, top2);
endmodule

// File: rtl/stsreg_volatile.sv
module stsreg_volatile (
  input  logic clk,
  input  logic rst_n,
  input  logic wel_set,
  input  logic wel_clr,
  input  logic flag_set,
  input  logic flag_clr,
  input  logic sr_accept,
  input  logic arr_accept,
  input  logic wcyc_done,
  output logic wel,
  output logic flag,
  output logic busy,
  output logic sr_commit
);
  import stsreg_pkg::*;

  cyc_kind_t kind_q;
  logic      cyc_end;

  assign cyc_end   = busy & wcyc_done;
  assign sr_commit = cyc_end & (kind_q == CYC_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel    <= 1'b0;
      flag   <= 1'b0;
      busy   <= 1'b0;
      kind_q <= CYC_ARRAY;
    end else begin
      if (flag_clr)      flag <= 1'b0;
      else if (flag_set) flag <= 1'b1;

      if (busy) begin
        if (wcyc_done) begin
          busy <= 1'b0;
          wel  <= 1'b0;
        end
      end else begin
        if (wel_clr)      wel <= 1'b0;
        else if (wel_set) wel <= 1'b1;
        if (sr_accept) begin
          busy   <= 1'b1;
          kind_q <= CYC_STATUS;
        end else if (arr_accept) begin
          busy   <= 1'b1;
          kind_q <= CYC_ARRAY;
        end
      end
    end
  end

  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !wcyc_done |=> busy);
  a_r7_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> !busy && !wel);
  a_r2_wel_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !wcyc_done |=> $stable(wel));
  a_r11_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && wcyc_done && !sr_accept && !arr_accept |=> !busy);
  a_r3_flag_only_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_set && !flag_clr |=> $stable(flag));
endmodule

// File: rtl/stsreg_nv_bits.sv
module stsreg_nv_bits #(
  parameter logic       RST_WPEN = 1'b0,
  parameter logic [1:0] RST_LOCK = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sr_accept,
  input  logic       sr_commit,
  input  logic       new_wpen,
  input  logic [1:0] new_lock,
  output logic       wpen,
  output logic [1:0] lock
);
  logic       pend_wpen;
  logic [1:0] pend_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_wpen <= RST_WPEN;
      pend_lock <= RST_LOCK;
      wpen      <= RST_WPEN;
      lock      <= RST_LOCK;
    end else begin
      if (sr_accept) begin
        pend_wpen <= new_wpen;
        pend_lock <= new_lock;
      end
      if (sr_commit) begin
        wpen <= pend_wpen;
        lock <= pend_lock;
      end
    end
  end

  a_r7_nv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_commit |=> $stable({wpen, lock}));
endmodule

// File: rtl/stsreg_guard.sv
module stsreg_guard #(
  parameter int         ADDR_W   = 11,
  parameter logic       RST_WPEN = 1'b0,
  parameter logic [1:0] RST_LOCK = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel_set,
  input  logic              wel_clr,
  input  logic              flag_set,
  input  logic              flag_clr,
  input  logic              sr_wr,
  input  logic [7:0]        sr_wdata,
  input  logic              wcyc_start,
  input  logic              wcyc_done,
  input  logic              wp_pin_hi,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        status_q,
  output logic              arr_wr_ok,
  output logic              sts_wr_ok
);
  import stsreg_pkg::*;

  logic       wel, flag, busy, wpen;
  logic [1:0] lock;
  logic       lock_hit_w, rom_mode, idle_en, data_ok;
  logic       sr_accept, arr_accept, sr_commit;
  logic       unused_data;

  assign unused_data = ^sr_wdata[6:4];

  stsreg_lock_decode #(.ADDR_W(ADDR_W)) u_dec (
    .lock (lock),
    .addr (wr_addr),
    .hit  (lock_hit_w)
  );

  assign rom_mode   = wpen & ~wp_pin_hi;
  assign idle_en    = wel & ~busy;
  assign data_ok    = (sr_wdata[1:0] == 2'b00);
  assign sts_wr_ok  = idle_en & ~rom_mode;
  assign arr_wr_ok  = idle_en & ~lock_hit_w;
  assign sr_accept  = sr_wr & sts_wr_ok & data_ok;
  assign arr_accept = wcyc_start & arr_wr_ok & ~sr_accept;

  stsreg_volatile u_vol (
    .clk        (clk),
    .rst_n      (rst_n),
    .wel_set    (wel_set),
    .wel_clr    (wel_clr),
    .flag_set   (flag_set),
    .flag_clr   (flag_clr),
    .sr_accept  (sr_accept),
    .arr_accept (arr_accept),
    .wcyc_done  (wcyc_done),
    .wel        (wel),
    .flag       (flag),
    .busy       (busy),
    .sr_commit  (sr_commit)
  );

  stsreg_nv_bits #(.RST_WPEN(RST_WPEN), .RST_LOCK(RST_LOCK)) u_nv (
    .clk       (clk),
    .rst_n     (rst_n),
    .sr_accept (sr_accept),
    .sr_commit (sr_commit),
    .new_wpen  (sr_wdata[7]),
    .new_lock  (sr_wdata[3:2]),
    .wpen      (wpen),
    .lock      (lock)
  );

  assign status_q = pack_status(wpen, flag, lock, wel, busy);

  a_r5_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q[1] || status_q[0]) |-> (!arr_wr_ok && !sts_wr_ok));
  a_r6_rom_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr && status_q[7] && !wp_pin_hi && !wcyc_start && !status_q[0] |=> !status_q[0]);
  a_r4_lock_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    wcyc_start && lock_hit_w && !sr_wr && !status_q[0] |=> !status_q[0]);
  a_r8_bad_bits: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr && (sr_wdata[1:0] != 2'b00) && !wcyc_start && !status_q[0] |=> !status_q[0]);
  a_r1_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[5:4] == 2'b00);
endmodule

// File: tb/sim_stsreg_guard.sv
`timescale 1ns/1ps
module sim_stsreg_guard;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wel_set = 0, wel_clr = 0, flag_set = 0, flag_clr = 0, sr_wr = 0;
  logic [7:0] sr_wdata = 8'h00;
  logic wcyc_start = 0, wcyc_done = 0, wp_pin_hi = 1;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] status_q;
  logic arr_wr_ok, sts_wr_ok;

  always #2.5 clk = ~clk;

  stsreg_guard #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wel_set(wel_set), .wel_clr(wel_clr),
    .flag_set(flag_set), .flag_clr(flag_clr), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
    .wcyc_start(wcyc_start), .wcyc_done(wcyc_done), .wp_pin_hi(wp_pin_hi),
    .wr_addr(wr_addr), .status_q(status_q), .arr_wr_ok(arr_wr_ok), .sts_wr_ok(sts_wr_ok)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  string tag = "R1";

  // reference state
  bit m_wpen, m_flag, m_wel, m_busy, m_kind_sts, m_pw;
  bit [1:0] m_lock, m_pl;

  function automatic bit protected_addr(bit [1:0] lk, int unsigned a);
    if (lk == 2'd0) return 0;
    if (lk == 2'd1) return a >= 32'h600;
    if (lk == 2'd2) return a >= 32'h400;
    return 1;
  endfunction

  function automatic bit [7:0] exp_status();
    bit [7:0] s = 8'h00;
    s[7] = m_wpen; s[6] = m_flag; s[3] = m_lock[1]; s[2] = m_lock[0];
    s[1] = m_wel; s[0] = m_busy;
    return s;
  endfunction

  function automatic bit exp_sok();
    return m_wel && !m_busy && !(m_wpen && !wp_pin_hi);
  endfunction

  function automatic bit exp_aok();
    return m_wel && !m_busy && !protected_addr(m_lock, wr_addr);
  endfunction

  task automatic chk(string t, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic idle();
    wel_set = 0; wel_clr = 0; flag_set = 0; flag_clr = 0; sr_wr = 0;
    wcyc_start = 0; wcyc_done = 0;
  endtask

  // called at a negedge with inputs applied; leaves at the next negedge
  task automatic step();
    bit sok, aok, n_wel, n_flag, n_busy, n_kind, n_wpen, n_pw;
    bit [1:0] n_lock, n_pl;
    #1;
    sok = exp_sok(); aok = exp_aok();
    chk({tag, " status"}, status_q, exp_status());
    chk({tag, " sts_wr_ok"}, {7'd0, sts_wr_ok}, {7'd0, sok});
    chk({tag, " arr_wr_ok"}, {7'd0, arr_wr_ok}, {7'd0, aok});
    n_wel = m_wel; n_flag = m_flag; n_busy = m_busy; n_kind = m_kind_sts;
    n_wpen = m_wpen; n_lock = m_lock; n_pw = m_pw; n_pl = m_pl;
    if (flag_clr) n_flag = 0; else if (flag_set) n_flag = 1;
    if (m_busy) begin
      if (wcyc_done) begin
        n_busy = 0; n_wel = 0;
        if (m_kind_sts) begin n_wpen = m_pw; n_lock = m_pl; end
      end
    end else begin
      if (wel_clr) n_wel = 0; else if (wel_set) n_wel = 1;
      if (sr_wr && sok && sr_wdata[1:0] == 2'b00) begin
        n_busy = 1; n_kind = 1; n_pw = sr_wdata[7]; n_pl = sr_wdata[3:2];
      end else if (wcyc_start && aok) begin
        n_busy = 1; n_kind = 0;
      end
    end
    @(posedge clk);
    m_wel = n_wel; m_flag = n_flag; m_busy = n_busy; m_kind_sts = n_kind;
    m_wpen = n_wpen; m_lock = n_lock; m_pw = n_pw; m_pl = n_pl;
    @(negedge clk);
    idle();
  endtask

  task automatic status_write(bit [7:0] d);
    wel_set = 1; step();
    sr_wr = 1; sr_wdata = d; step();
    wcyc_done = 1; step();
  endtask

  task automatic arr_probe(int unsigned a, bit exp, string t);
    wr_addr = AW'(a); #1;
    chk(t, {7'd0, arr_wr_ok}, {7'd0, exp});
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h5eed_0031;
    void'($urandom(seed));
    m_wpen = 0; m_lock = 0; m_flag = 0; m_wel = 0; m_busy = 0;
    m_kind_sts = 0; m_pw = 0; m_pl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 reset status", status_q, 8'h00);
    chk("R5 reset sts_wr_ok", {7'd0, sts_wr_ok}, 8'h00);
    @(negedge clk);

    // R2 write-enable set/clear, clear wins
    tag = "R2";
    wel_set = 1; step();
    chk("R2 wel set", status_q, 8'h02);
    wel_set = 1; wel_clr = 1; step();
    chk("R2 clear wins", status_q, 8'h00);

    // R3 flag
    tag = "R3";
    flag_set = 1; step();
    chk("R3 flag set", status_q, 8'h40);
    flag_set = 1; flag_clr = 1; step();
    chk("R3 flag clear wins", status_q, 8'h00);

    // R7 status write, ignored data bits
    tag = "R7";
    wel_set = 1; step();
    sr_wr = 1; sr_wdata = 8'hFC; step();
    chk("R7 busy during write", status_q, 8'h03);
    wel_set = 1; wel_clr = 0; step();   // R2: ignored while busy
    chk("R2 ignored while busy", status_q, 8'h03);
    wcyc_done = 1; step();
    chk("R7 commit", status_q, 8'h8C);

    // R6 read-only mode
    tag = "R6";
    wp_pin_hi = 0;
    wel_set = 1; step();
    #1 chk("R6 sts_wr_ok low", {7'd0, sts_wr_ok}, 8'h00);
    sr_wr = 1; sr_wdata = 8'h00; step();
    chk("R6 refused", status_q, 8'h8E);
    wp_pin_hi = 1;
    sr_wr = 1; sr_wdata = 8'h04; step();
    wcyc_done = 1; step();
    chk("R6 pin high allows", status_q, 8'h04);

    // R4 lock map, R9 array cycle
    tag = "R4";
    wel_set = 1; step();
    arr_probe(32'h5FF, 1, "R4 01 below");
    arr_probe(32'h600, 0, "R4 01 first locked");
    arr_probe(32'h7FF, 0, "R4 01 top");
    wcyc_start = 1; wr_addr = 11'h600; step();
    chk("R4 locked start refused", status_q, 8'h06);
    tag = "R9";
    wcyc_start = 1; wr_addr = 11'h5FF; step();
    chk("R9 array busy", status_q, 8'h07);
    wcyc_done = 1; step();
    chk("R9 array done", status_q, 8'h04);
    tag = "R4";
    status_write(8'h08);
    wel_set = 1; step();
    arr_probe(32'h3FF, 1, "R4 10 below");
    arr_probe(32'h400, 0, "R4 10 first locked");
    status_write(8'h0C);
    wel_set = 1; step();
    arr_probe(32'h000, 0, "R4 11 zero");
    status_write(8'h00);
    wel_set = 1; step();
    arr_probe(32'h7FF, 1, "R4 00 top");

    // R9 status wins over array start in the same cycle
    tag = "R9";
    sr_wr = 1; sr_wdata = 8'h04; wcyc_start = 1; wr_addr = 11'h000; step();
    wcyc_done = 1; step();
    chk("R9 status over array", status_q, 8'h04);

    // R8 bad low data bits
    tag = "R8";
    wel_set = 1; step();
    sr_wr = 1; sr_wdata = 8'h81; step();
    chk("R8 refused", status_q, 8'h06);

    // R10 pin falls during status write
    tag = "R10";
    sr_wr = 1; sr_wdata = 8'h80; step();
    wp_pin_hi = 0; step();
    wcyc_done = 1; step();
    chk("R10 commit despite pin", status_q, 8'h80);
    wel_set = 1; step();
    sr_wr = 1; sr_wdata = 8'h00; step();
    chk("R10 later refused", status_q, 8'h82);

    // R11 spurious done
    tag = "R11";
    wcyc_done = 1; step();
    chk("R11 idle done", status_q, 8'h82);
    wp_pin_hi = 1;
    status_write(8'h00);

    // random phase
    tag = "R5 random";
    for (int i = 0; i < 4000; i++) begin
      wel_set   = ($urandom_range(0, 5) == 0);
      wel_clr   = ($urandom_range(0, 19) == 0);
      flag_set  = ($urandom_range(0, 9) == 0);
      flag_clr  = ($urandom_range(0, 9) == 0);
      sr_wr     = ($urandom_range(0, 7) == 0);
      sr_wdata  = 8'($urandom());
      if ($urandom_range(0, 3) != 0) sr_wdata[1:0] = 2'b00;
      wcyc_start = ($urandom_range(0, 4) == 0);
      wr_addr   = AW'($urandom());
      wcyc_done = m_busy ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 39) == 0);
      if ($urandom_range(0, 29) == 0) wp_pin_hi = ~wp_pin_hi;
      step();
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule